// File: doc/BRIEF.md
# Four-Channel DMA Channel Register File

This block is the software-visible register set of a legacy-style four-channel DMA controller. A host reaches it over a narrow 8-bit I/O port bus. Each channel holds a 16-bit current address and a 16-bit current count, along with base copies of both. Because the bus is only eight bits wide, each 16-bit register is written and read as two bytes through one port. A single byte-pointer flip-flop, shared by all channels, selects which byte an access reaches.

The block also has:
- a per-channel mode register;
- a single-channel mask port;
- a byte-pointer clear port;
- a master reset port;
- a terminal-count status register.

A per-channel transfer-tick input stands in for real bus cycles. Each tick steps the address up and the count down. This lets terminal count, single mode and auto-initialise mode be exercised without any memory traffic.

The count is programmed as the transfer length minus one. When a tick arrives with the count at zero, terminal count is reached and the count wraps to 0xFFFF. What happens next depends on the channel's mode:
- **Single mode:** the channel masks itself.
- **Auto-initialise mode:** the current address and count reload from the base copies, and the channel stays live.

Port map (io_addr):

| io_addr | Function |
|---|---|
| 2n | Address port of channel n |
| 2n+1 | Count port of channel n |
| 8 | Status (read) |
| 9 | Mode (write) |
| 10 | Single mask (write) |
| 11 | Byte-pointer clear (write) |
| 12 | Master reset (write) |

Top module: `dma4_regfile`

## Requirements
- R1: After reset, all four channels are masked (mask_o = 4'hF). All address, count, base, mode and status values are zero, and the byte pointer selects the low byte.
- R2: Every read or write at io_addr 0..7 toggles the shared byte pointer. Any write to io_addr 11 returns it to the low byte.
- R3: Address and count ports take and return the low byte first and the high byte second. Writes update both the current and the base copy.
- R4: A write to io_addr 10 selects a channel with io_wdata[1:0]. io_wdata[2]=1 masks that channel and io_wdata[2]=0 unmasks it. Other channels are unchanged.
- R5: A write to io_addr 9 selects a channel with io_wdata[1:0] and stores io_wdata[7:2] as that channel's mode, shown on mode_o[6n+5:6n]. Within the mode, io_wdata[4]=1 selects auto-initialise and io_wdata[7:6]=2'b11 selects cascade.
- R6: A tick on an unmasked channel that is not in cascade mode, with nonzero count, decrements the count and increments the address. A tick on a masked or cascade channel changes nothing.
- R7: A tick at count 0 in single mode sets status bit n, leaves the count at 0xFFFF, increments the address and sets the channel's mask bit.
- R8: A tick at count 0 in auto-initialise mode sets status bit n and reloads the current address and count from the base copies. The channel stays unmasked.
- R9: A read of io_addr 8 returns the four terminal-count flags in bits [3:0], bit n for channel n, and clears them at that access.
- R10: A write to io_addr 12 masks all channels and returns the byte pointer to the low byte, leaving address and count contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the addressed register |
| xfer_tick | input | 4 | Per-channel transfer tick |
| mask_o | output | 4 | Per-channel mask bits |
| mode_o | output | 24 | Stored mode bits, six per channel |

## Verification
Register writes, mask and mode updates, and tick effects all appear one cycle after the clock edge that accepts them. Read data is combinational, so it reflects the register state during the access cycle itself. The byte-pointer toggle and the status clear take effect at the edge that ends the read. The bench drives every strobe just after a falling edge and samples io_rdata and mask_o one nanosecond later, always before the next rising edge. Each result is therefore observed exactly in the cycle where it is due.

// File: rtl/dma4_regfile.sv
module dma4_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  xfer_tick,
  output logic [3:0]  mask_o,
  output logic [23:0] mode_o
);
  localparam int NCH = 4;
  localparam logic [3:0] P_STAT = 4'd8, P_MODE = 4'd9, P_MASK = 4'd10,
                         P_CLRP = 4'd11, P_MRST = 4'd12;

  logic [15:0] cur_a [NCH];
  logic [15:0] cur_c [NCH];
  logic [15:0] base_a [NCH];
  logic [15:0] base_c [NCH];
  logic [5:0]  mode_r [NCH];
  logic [3:0]  mask_r, tc_r, tick_ok, tc_now;
  logic        hi_ff;

  wire       sel_ch = (io_addr[3] == 1'b0);
  wire [1:0] ach    = io_addr[2:1];
  wire       is_cnt = io_addr[0];
  wire       ch_acc = sel_ch & (io_wr | io_rd);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign tick_ok[g] = xfer_tick[g] & ~mask_r[g] & (mode_r[g][5:4] != 2'b11);
      assign tc_now[g]  = tick_ok[g] & (cur_c[g] == 16'h0000);
      assign mode_o[6*g +: 6] = mode_r[g];
    end
  endgenerate

  assign mask_o = mask_r;

  logic [15:0] rsel;
  always_comb begin
    rsel = is_cnt ? cur_c[ach] : cur_a[ach];
    io_rdata = 8'h00;
    if (sel_ch)                io_rdata = hi_ff ? rsel[15:8] : rsel[7:0];
    else if (io_addr == P_STAT) io_rdata = {4'h0, tc_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_ff  <= 1'b0;
      mask_r <= 4'hF;
      tc_r   <= 4'h0;
      for (int i = 0; i < NCH; i++) begin
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        base_a[i] <= '0;
        base_c[i] <= '0;
        mode_r[i] <= '0;
      end
    end else begin
      if (io_wr && (io_addr == P_CLRP || io_addr == P_MRST)) hi_ff <= 1'b0;
      else if (ch_acc)                                        hi_ff <= ~hi_ff;

      tc_r <= ((io_rd && io_addr == P_STAT) ? 4'h0 : tc_r) | tc_now;

      for (int i = 0; i < NCH; i++) begin
        if (io_wr && sel_ch && ach == 2'(i) && !is_cnt) begin
          if (hi_ff) begin cur_a[i][15:8] <= io_wdata; base_a[i][15:8] <= io_wdata; end
          else       begin cur_a[i][7:0]  <= io_wdata; base_a[i][7:0]  <= io_wdata; end
        end else if (tick_ok[i]) begin
          cur_a[i] <= (tc_now[i] && mode_r[i][2]) ? base_a[i] : cur_a[i] + 16'd1;
        end

        if (io_wr && sel_ch && ach == 2'(i) && is_cnt) begin
          if (hi_ff) begin cur_c[i][15:8] <= io_wdata; base_c[i][15:8] <= io_wdata; end
          else       begin cur_c[i][7:0]  <= io_wdata; base_c[i][7:0]  <= io_wdata; end
        end else if (tick_ok[i]) begin
          cur_c[i] <= (tc_now[i] && mode_r[i][2]) ? base_c[i] : cur_c[i] - 16'd1;
        end

        if (tc_now[i] && !mode_r[i][2]) mask_r[i] <= 1'b1;
      end

      if (io_wr && io_addr == P_MODE) mode_r[io_wdata[1:0]] <= io_wdata[7:2];
      if (io_wr && io_addr == P_MASK) mask_r[io_wdata[1:0]] <= io_wdata[2];
      if (io_wr && io_addr == P_MRST) mask_r <= 4'hF;
    end
  end
endmodule

// File: rtl/dma4_regfile_chk.sv
module dma4_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [3:0]  xfer_tick,
  input logic [3:0]  mask_o,
  input logic [23:0] mode_o,
  input logic        hi_ff,
  input logic [3:0]  tc_r
);
  p_reset_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mask_o == 4'hF && tc_r == 4'h0 && !hi_ff));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd11) |=> !hi_ff);

  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd10) |=> (mask_o[$past(io_wdata[1:0])] == $past(io_wdata[2])));

  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 4'd8 && xfer_tick == 4'h0) |=> (tc_r == 4'h0));

  p_master_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd12) |=> (mask_o == 4'hF && !hi_ff));

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_auto
      p_auto_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_tick[g] && !mask_o[g] && mode_o[6*g+2] && mode_o[6*g+5 -: 2] != 2'b11
         && !(io_wr && (io_addr == 4'd10 || io_addr == 4'd12))) |=> !mask_o[g]);
    end
  endgenerate
endmodule

bind dma4_regfile dma4_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .xfer_tick(xfer_tick), .mask_o(mask_o), .mode_o(mode_o),
  .hi_ff(hi_ff), .tc_r(tc_r)
);

// File: tb/tb_dma4_regfile.sv
`timescale 1ns/1ps
module tb_dma4_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  xfer_tick = '0;
  logic [3:0]  mask_o;
  logic [23:0] mode_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma4_regfile dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'd11, 8'h00);
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(4'd11, 8'h00);
    wr(a, v[7:0]);
    wr(a, v[15:8]);
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    @(negedge clk); xfer_tick = m;
    repeat (n) @(negedge clk);
    xfer_tick = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] s;
    #1 check(mask_o == 4'hF, "R1 mask", mask_o, 4'hF);
    check(mode_o == 24'h0, "R1 mode", mode_o, 0);
    rd(4'd0, s);
    check(s == 8'h00, "R1 ch0 addr low", s, 0);
    rd16(4'd7, v);
    check(v == 16'h0, "R1 ch3 count", v, 0);
    rd(4'd8, s);
    check(s == 8'h00, "R1 status", s, 0);
  endtask

  task automatic t_byteptr;
    logic [7:0] b0, b1;
    wr16(4'd2, 16'h1234);
    wr(4'd11, 8'h00); rd(4'd2, b0); rd(4'd2, b1);
    check(b0 == 8'h34, "R3 low first", b0, 8'h34);
    check(b1 == 8'h12, "R3 high second", b1, 8'h12);
    wr16(4'd3, 16'h0005);
    wr(4'd11, 8'h00);
    wr(4'd4, 8'hAA);
    wr(4'd11, 8'h00);
    wr(4'd4, 8'hBB);
    wr(4'd4, 8'hCC);
    wr(4'd11, 8'h00); rd(4'd4, b0); rd(4'd4, b1);
    check({b1, b0} == 16'hCCBB, "R2 clear returns pointer to low", {b1, b0}, 16'hCCBB);
  endtask

  task automatic t_mask;
    wr(4'd10, 8'h01);
    #1 check(mask_o == 4'hD, "R4 unmask ch1", mask_o, 4'hD);
    wr(4'd10, 8'h05);
    #1 check(mask_o == 4'hF, "R4 mask ch1", mask_o, 4'hF);
    wr(4'd10, 8'h01);
  endtask

  task automatic t_mode;
    wr(4'd9, 8'h45);
    #1 check(mode_o[11:6] == 6'h11, "R5 ch1 mode", mode_o[11:6], 6'h11);
    check(mode_o[5:0] == 6'h00 && mode_o[23:12] == 12'h0, "R5 others", mode_o, 24'h440);
  endtask

  task automatic t_tick;
    logic [15:0] v; logic [7:0] s;
    tick(4'b0011, 2);
    rd16(4'd3, v);
    check(v == 16'h0003, "R6 count down", v, 3);
    rd16(4'd2, v);
    check(v == 16'h1236, "R6 address up", v, 16'h1236);
    rd16(4'd0, v);
    check(v == 16'h0000, "R6 masked ch0 unchanged", v, 0);
    wr(4'd9, 8'hC3);
    wr(4'd10, 8'h03);
    tick(4'b1000, 1);
    rd16(4'd7, v);
    check(v == 16'h0000, "R6 cascade ch3 count unchanged", v, 0);
    rd(4'd8, s);
    check(s == 8'h00, "R6 cascade no terminal count", s, 0);
    wr(4'd10, 8'h07);
  endtask

  task automatic t_tc_single;
    logic [15:0] v; logic [7:0] s;
    tick(4'b0010, 3);
    #1 check(mask_o[1] == 1'b0, "R7 still live before tc", mask_o, 4'hD);
    tick(4'b0010, 1);
    #1 check(mask_o[1] == 1'b1, "R7 self mask", mask_o, 4'hF);
    rd16(4'd3, v);
    check(v == 16'hFFFF, "R7 count wraps", v, 16'hFFFF);
    rd16(4'd2, v);
    check(v == 16'h123A, "R7 address", v, 16'h123A);
    rd(4'd8, s);
    check(s == 8'h02, "R9 status bit1", s, 2);
    rd(4'd8, s);
    check(s == 8'h00, "R9 cleared by read", s, 0);
  endtask

  task automatic t_auto;
    logic [15:0] v; logic [7:0] s;
    wr(4'd9, 8'h56);
    check(mode_o[14] == 1'b1, "R5 auto bit ch2", mode_o[17:12], 6'h15);
    wr16(4'd4, 16'h0100);
    wr16(4'd5, 16'h0001);
    wr(4'd10, 8'h02);
    tick(4'b0100, 2);
    #1 check(mask_o[2] == 1'b0, "R8 stays unmasked", mask_o, 4'hB);
    rd16(4'd5, v);
    check(v == 16'h0001, "R8 count reload", v, 1);
    rd16(4'd4, v);
    check(v == 16'h0100, "R8 address reload", v, 16'h0100);
    rd(4'd8, s);
    check(s == 8'h04, "R8 status bit2", s, 4);
    tick(4'b0100, 1);
    rd16(4'd5, v);
    check(v == 16'h0000, "R8 runs on after reload", v, 0);
  endtask

  task automatic t_master;
    logic [15:0] v;
    wr(4'd11, 8'h00);
    wr(4'd6, 8'h77);
    wr(4'd12, 8'h00);
    #1 check(mask_o == 4'hF, "R10 all masked", mask_o, 4'hF);
    rd(4'd2, v[7:0]);
    check(v[7:0] == 8'h3A, "R10 pointer low and data kept", v[7:0], 8'h3A);
    rd16(4'd3, v);
    check(v == 16'hFFFF, "R10 count kept", v, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_byteptr;
    t_mask;
    t_mode;
    t_tick;
    t_tc_single;
    t_auto;
    t_master;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule